// File: doc/BRIEF.md
# Low-Power Mode Register Sequencer

This block owns the sleep pin and the chip-select and write-enable pins of a 512K x 16 asynchronous low-power RAM whenever the RAM is not on loan to the data-access controller. It programs the RAM's 5-bit low-power configuration. To do so it pulls the sleep pin low, runs one write cycle whose address bus carries the configuration word, and then releases the sleep pin. The RAM takes the new word on that release. The block also puts the RAM to sleep and wakes it again. It keeps the sleep pin low for a minimum time, waits out the recovery period after an array-off sleep, and reports the power state, the address window that survives sleep, and whether the stored contents can still be trusted.

A new configuration arrives on a valid/ready channel. `cfg_ready` is high only when the sequencer is idle in standby. While it is low, the producer holds `cfg_valid` and `cfg_word` steady, and a word is taken on a clock edge where both are high. Sleep and access requests are plain levels. When the access controller is granted, it drives the RAM pins itself, and it must have chip select high before it drops `acc_req`. When `sleep_req`, `acc_req` and a valid word are all present in standby, the word is served first, then the sleep request, then the access request.

Configuration word fields: bits [1:0] select the area (00 full, 10 half, 11 quarter, 01 reserved), bit 2 selects top (1) or bottom (0), bit 3 selects reduced-size mode (1) or partial-retention mode (0), and bit 4 turns the array off during sleep.

Top module: `lpm_sequencer`

## Requirements
- R1: Reset produces the following state: `pwr_state` is INIT, `mem_zz_n` and `mem_cs_n` are high, there is no grant, `cfg_ready` is low, and `contents_valid` is 1. INIT lasts exactly PWRUP_CYC cycles after reset is released, and the block then enters STANDBY with `cfg_value` = 5'b00000.
- R2: `cfg_ready` is high only in STANDBY. A word is accepted only on an edge where `cfg_valid` and `cfg_ready` are both high. A word held during a grant is not taken and does not move the sleep pin.
- R3: An accepted word first lowers `mem_zz_n` while `mem_cs_n` stays high. On the next cycle a write starts: `mem_cs_n` and `mem_we_n` are low for WR_CYC cycles, `mem_addr[4:0]` equals the word, and the upper address bits are zero.
- R4: During programming, `mem_zz_n` stays low for exactly MIN_ZZ_CYC cycles. `cfg_value` changes only in the cycle in which `mem_zz_n` returns high.
- R5: A word with area code 01 is rejected. `cfg_err` rises, the sleep pin does not move, and `cfg_value` keeps its value. `cfg_err` clears on the next accepted legal word.
- R6: A `sleep_req` in STANDBY lowers `mem_zz_n`. The sleep lasts for as long as the request is held, and never less than MIN_ZZ_CYC cycles. With bit 4 of the configuration clear, the state is RETAIN and the block returns to STANDBY on wake.
- R7: With bit 4 set, sleep reports DEEP and `contents_valid` drops in the first sleep cycle. After wake, DEEP is held for REC_CYC cycles with `mem_zz_n` high and no grant.
- R8: `ret_lo`/`ret_hi` give the surviving window: the full array 0x00000–0x7FFFF for area 00. The half area is 0x00000–0x3FFFF at the bottom or 0x40000–0x7FFFF at the top. The quarter area is 0x00000–0x1FFFF at the bottom or 0x60000–0x7FFFF at the top.
- R9: `size_limited` equals bit 3 of the stored configuration. It stays in force through sleep and wake until the configuration is rewritten.
- R10: `acc_gnt` rises one cycle after `acc_req` in STANDBY, and the state becomes ACTIVE. Sleep requests are ignored while the grant is held. A valid word wins over sleep, and sleep wins over access. `contents_valid` returns to 1 when a grant starts.
- R11: `pwr_state` encodes 0 INIT, 1 ACTIVE, 2 STANDBY, 3 RETAIN, 4 DEEP, 5 MODESET (programming in progress).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Sequencer can take a word |
| cfg_word | input | 5 | Configuration word |
| sleep_req | input | 1 | Level request to sleep |
| acc_req | input | 1 | Access controller asks for the RAM |
| acc_gnt | output | 1 | RAM handed to the access controller |
| mem_zz_n | output | 1 | RAM sleep pin, active low |
| mem_cs_n | output | 1 | RAM chip select for register writes |
| mem_we_n | output | 1 | RAM write enable for register writes |
| mem_addr | output | AW | RAM address carrying the configuration |
| pwr_state | output | 3 | Power state code |
| cfg_value | output | 5 | Configuration currently stored in the RAM |
| cfg_err | output | 1 | Last offered word was reserved |
| contents_valid | output | 1 | Retained contents are trustworthy |
| size_limited | output | 1 | Reduced-size mode in force |
| ret_lo | output | AW | Lowest retained address |
| ret_hi | output | AW | Highest retained address |

## Verification
The hardest situation to reach from the ports is a wake from array-off sleep while an access request is already pending. The stimulus has to program bit 4 through a complete register cycle, then sleep, and raise `acc_req` in the middle of the sleep. Only then can it show that the grant stays low for the whole recovery window and that `contents_valid` comes back with the first grant. The register-update instant is also delicate: the bench records `cfg_value` on the last low cycle of the sleep pin and again on the first high cycle, so an update made one cycle early or late is caught. The priority rule is exercised by raising a word, a sleep request and an access request on the same edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    PWR_INIT    = 3'd0,
    PWR_ACTIVE  = 3'd1,
    PWR_STANDBY = 3'd2,
    PWR_RETAIN  = 3'd3,
    PWR_DEEP    = 3'd4,
    PWR_MODESET = 3'd5
  } pwr_e;

  typedef enum logic [2:0] {
    SQ_INIT, SQ_IDLE, SQ_GRANT, SQ_PZZ, SQ_PWR, SQ_PHOLD, SQ_SLEEP, SQ_RECOVER
  } seq_e;

  // bit 4 array off in sleep, bit 3 reduced size, bit 2 top, bits 1:0 area
  typedef struct packed {
    logic       off_on_sleep;
    logic       size_cut;
    logic       top_sel;
    logic [1:0] area;
  } lpm_cfg_t;

  localparam logic [1:0] AREA_FULL    = 2'b00;
  localparam logic [1:0] AREA_RSVD    = 2'b01;
  localparam logic [1:0] AREA_HALF    = 2'b10;
  localparam logic [1:0] AREA_QUARTER = 2'b11;

  localparam lpm_cfg_t CFG_DEFAULT = '0;

  function automatic logic zz_low_in(seq_e s);
    return (s == SQ_PZZ) || (s == SQ_PWR) || (s == SQ_PHOLD) || (s == SQ_SLEEP);
  endfunction

endpackage

// File: rtl/lpm_region.sv
module lpm_region
  import lpm_pkg::*;
#(
  parameter int AW = 19
) (
  input  lpm_cfg_t        cfg_i,
  output logic [AW-1:0]   lo_o,
  output logic [AW-1:0]   hi_o
);
  localparam logic [AW-1:0] TOP_ADDR  = '1;
  localparam logic [AW-1:0] HALF_SPAN = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] QUAR_SPAN = {2'b00, {(AW-2){1'b1}}};

  logic [AW-1:0] span;
  logic          partial;

  always_comb begin
    partial = 1'b1;
    span    = TOP_ADDR;
    unique case (cfg_i.area)
      AREA_HALF:    span = HALF_SPAN;
      AREA_QUARTER: span = QUAR_SPAN;
      default:      partial = 1'b0;
    endcase
    if (partial && cfg_i.top_sel) begin
      lo_o = TOP_ADDR - span;
      hi_o = TOP_ADDR;
    end else begin
      lo_o = '0;
      hi_o = span;
    end
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int PWRUP_CYC   = 10000,
  parameter int WR_CYC      = 4,
  parameter int MIN_ZZ_CYC  = 500,
  parameter int REC_CYC     = 10000,
  parameter int WRSTART_LIM = 50
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_valid,
  output logic     cfg_ready,
  input  lpm_cfg_t cfg_word,
  input  logic     sleep_req,
  input  logic     acc_req,
  output logic     acc_gnt,
  output logic     zz_n,
  output logic     cs_n,
  output logic     we_n,
  output lpm_cfg_t wr_cfg,
  output lpm_cfg_t cfg_q,
  output logic     cfg_err,
  output logic     contents_valid,
  output pwr_e     pwr_state
);
  localparam int MAXC = (PWRUP_CYC > REC_CYC) ?
                        ((PWRUP_CYC > WR_CYC) ? PWRUP_CYC : WR_CYC) :
                        ((REC_CYC > WR_CYC) ? REC_CYC : WR_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam int ZW = $clog2(MIN_ZZ_CYC + 1);
  localparam logic [CW-1:0] PWRUP_LAST = CW'(PWRUP_CYC - 1);
  localparam logic [CW-1:0] WR_LAST    = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] REC_LAST   = CW'(REC_CYC - 1);
  localparam logic [ZW-1:0] MIN_LAST   = ZW'(MIN_ZZ_CYC - 1);

  seq_e          st, st_nx;
  logic [CW-1:0] cnt;
  logic [ZW-1:0] zz_cnt;
  lpm_cfg_t      pend_q;
  logic          accept, rsvd, min_done;

  assign cfg_ready = (st == SQ_IDLE);
  assign accept    = cfg_valid && cfg_ready;
  assign rsvd      = (cfg_word.area == AREA_RSVD);
  assign min_done  = (zz_cnt == MIN_LAST);

  always_comb begin
    st_nx = st;
    unique case (st)
      SQ_INIT:    if (cnt == PWRUP_LAST) st_nx = SQ_IDLE;
      SQ_IDLE: begin
        if (accept)         st_nx = rsvd ? SQ_IDLE : SQ_PZZ;
        else if (sleep_req) st_nx = SQ_SLEEP;
        else if (acc_req)   st_nx = SQ_GRANT;
      end
      SQ_GRANT:   if (!acc_req) st_nx = SQ_IDLE;
      SQ_PZZ:     st_nx = SQ_PWR;
      SQ_PWR:     if (cnt == WR_LAST) st_nx = SQ_PHOLD;
      SQ_PHOLD:   if (min_done) st_nx = SQ_IDLE;
      SQ_SLEEP:   if (!sleep_req && min_done)
                    st_nx = cfg_q.off_on_sleep ? SQ_RECOVER : SQ_IDLE;
      SQ_RECOVER: if (cnt == REC_LAST) st_nx = SQ_IDLE;
      default:    st_nx = SQ_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= SQ_INIT;
      cnt            <= '0;
      zz_cnt         <= '0;
      pend_q         <= CFG_DEFAULT;
      cfg_q          <= CFG_DEFAULT;
      cfg_err        <= 1'b0;
      contents_valid <= 1'b1;
    end else begin
      st <= st_nx;
      if (st_nx != st) cnt <= '0;
      else if (st == SQ_INIT || st == SQ_PWR || st == SQ_RECOVER) cnt <= cnt + 1'b1;

      if (zz_low_in(st) && zz_low_in(st_nx))
        zz_cnt <= min_done ? zz_cnt : zz_cnt + 1'b1;
      else
        zz_cnt <= '0;

      if (accept) begin
        cfg_err <= rsvd;
        if (!rsvd) pend_q <= cfg_word;
      end
      if (st == SQ_PHOLD && st_nx == SQ_IDLE) cfg_q <= pend_q;

      if (st == SQ_IDLE && st_nx == SQ_SLEEP && cfg_q.off_on_sleep) contents_valid <= 1'b0;
      else if (st == SQ_IDLE && st_nx == SQ_GRANT) contents_valid <= 1'b1;
    end
  end

  assign acc_gnt = (st == SQ_GRANT);
  assign zz_n    = !zz_low_in(st);
  assign cs_n    = (st != SQ_PWR);
  assign we_n    = (st != SQ_PWR);
  assign wr_cfg  = pend_q;

  always_comb begin
    unique case (st)
      SQ_INIT:                    pwr_state = PWR_INIT;
      SQ_GRANT:                   pwr_state = PWR_ACTIVE;
      SQ_PZZ, SQ_PWR, SQ_PHOLD:   pwr_state = PWR_MODESET;
      SQ_SLEEP:                   pwr_state = cfg_q.off_on_sleep ? PWR_DEEP : PWR_RETAIN;
      SQ_RECOVER:                 pwr_state = PWR_DEEP;
      default:                    pwr_state = PWR_STANDBY;
    endcase
  end

  AST_ZZ_FALL_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zz_n) |-> cs_n && $past(cs_n)) else $error("zz fell with chip selected"); // R3
  AST_WRITE_STARTS_IN_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> (!zz_n && int'(zz_cnt) < WRSTART_LIM)) else $error("register write late"); // R3
  AST_MIN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zz_n) |-> ($past(zz_cnt) == MIN_LAST)) else $error("sleep pin low too short"); // R4
  AST_CFG_ONLY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $rose(zz_n)) else $error("config changed off the zz rise"); // R4
  AST_RESERVED_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> ($stable(cfg_q) && zz_n)) else $error("reserved word touched config"); // R5
  AST_DEEP_LOSES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_state == PWR_DEEP) && !zz_n) |-> !contents_valid) else $error("valid kept in deep"); // R7
  AST_GNT_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> (zz_n && we_n && pwr_state == PWR_ACTIVE)) else $error("grant while not awake"); // R10
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int AW          = 19,
  parameter int PWRUP_CYC   = 10000,
  parameter int WR_CYC      = 4,
  parameter int MIN_ZZ_CYC  = 500,
  parameter int REC_CYC     = 10000,
  parameter int WRSTART_LIM = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  output logic          cfg_ready,
  input  logic [4:0]    cfg_word,
  input  logic          sleep_req,
  input  logic          acc_req,
  output logic          acc_gnt,
  output logic          mem_zz_n,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [2:0]    pwr_state,
  output logic [4:0]    cfg_value,
  output logic          cfg_err,
  output logic          contents_valid,
  output logic          size_limited,
  output logic [AW-1:0] ret_lo,
  output logic [AW-1:0] ret_hi
);
  lpm_cfg_t cfg_q, wr_cfg, word_in;
  pwr_e     pwr;

  assign word_in = lpm_cfg_t'(cfg_word);

  lpm_fsm #(
    .PWRUP_CYC(PWRUP_CYC), .WR_CYC(WR_CYC), .MIN_ZZ_CYC(MIN_ZZ_CYC),
    .REC_CYC(REC_CYC), .WRSTART_LIM(WRSTART_LIM)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_word(word_in), .sleep_req(sleep_req), .acc_req(acc_req), .acc_gnt(acc_gnt),
    .zz_n(mem_zz_n), .cs_n(mem_cs_n), .we_n(mem_we_n), .wr_cfg(wr_cfg),
    .cfg_q(cfg_q), .cfg_err(cfg_err), .contents_valid(contents_valid), .pwr_state(pwr)
  );

  lpm_region #(.AW(AW)) u_region (.cfg_i(cfg_q), .lo_o(ret_lo), .hi_o(ret_hi));

  assign mem_addr     = mem_we_n ? '0 : {{(AW-5){1'b0}}, wr_cfg};
  assign pwr_state    = pwr;
  assign cfg_value    = cfg_q;
  assign size_limited = cfg_q.size_cut;
endmodule

// File: tb/lpm_sequencer_bench.sv
module lpm_sequencer_bench;
  localparam int P = 20, W = 4, M = 30, R = 40;

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0, sleep_req = 0, acc_req = 0;
  logic [4:0] cfg_word = '0;
  logic cfg_ready, acc_gnt, mem_zz_n, mem_cs_n, mem_we_n, cfg_err, contents_valid, size_limited;
  logic [18:0] mem_addr, ret_lo, ret_hi;
  logic [2:0] pwr_state;
  logic [4:0] cfg_value;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  lpm_sequencer #(.AW(19), .PWRUP_CYC(P), .WR_CYC(W), .MIN_ZZ_CYC(M), .REC_CYC(R),
                  .WRSTART_LIM(50)) u_lpm_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_word(cfg_word), .sleep_req(sleep_req), .acc_req(acc_req), .acc_gnt(acc_gnt),
    .mem_zz_n(mem_zz_n), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .pwr_state(pwr_state), .cfg_value(cfg_value), .cfg_err(cfg_err),
    .contents_valid(contents_valid), .size_limited(size_limited),
    .ret_lo(ret_lo), .ret_hi(ret_hi));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    int n;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 state in reset", int'(pwr_state), 0);
    check("R1 pins in reset", int'({mem_zz_n, mem_cs_n, acc_gnt, cfg_ready}), 4'b1100);
    check("R1 contents valid", int'(contents_valid), 1);
    rst_n = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (pwr_state == 3'd0 && n < 1000);
    check("R1 init length", n, P);
    check("R11 standby code", int'(pwr_state), 2);
    check("R1 default config", int'(cfg_value), 0);
    check("R8 default lo", int'(ret_lo), 0);
    check("R8 default hi", int'(ret_hi), 'h7FFFF);
  endtask

  task automatic t_program(input logic [4:0] w, input int lo, input int hi, input bit others);
    logic [4:0] old, last_low;
    int zl, wl, first_we;
    @(negedge clk);
    while (!cfg_ready) @(negedge clk);
    old = cfg_value;
    cfg_valid = 1; cfg_word = w;
    if (others) begin sleep_req = 1; acc_req = 1; end
    @(negedge clk);
    cfg_valid = 0; sleep_req = 0; acc_req = 0;
    check("R3 zz low cs high", int'({mem_zz_n, mem_cs_n}), 2'b01);
    check("R11 modeset code", int'(pwr_state), 5);
    check("R2 ready dropped", int'(cfg_ready), 0);
    if (others) check("R10 word beats sleep and access", int'(acc_gnt), 0);
    zl = 1; wl = 0; first_we = 0; last_low = cfg_value;
    while (!mem_zz_n && zl < 1000) begin
      last_low = cfg_value;
      @(negedge clk);
      if (!mem_zz_n) begin
        zl++;
        if (!mem_we_n) begin
          wl++;
          if (wl == 1) first_we = zl;
          check("R3 write address", int'(mem_addr), int'(w));
          check("R3 cs low in write", int'(mem_cs_n), 0);
        end
      end
    end
    check("R3 write starts next cycle", first_we, 2);
    check("R3 write length", wl, W);
    check("R4 zz low length", zl, M);
    check("R4 old value until rise", int'(last_low), int'(old));
    check("R4 new value at rise", int'(cfg_value), int'(w));
    check("R8 lo", int'(ret_lo), lo);
    check("R8 hi", int'(ret_hi), hi);
    check("R9 size flag", int'(size_limited), int'(w[3]));
    check("R5 err clear", int'(cfg_err), 0);
    check("R11 back to standby", int'(pwr_state), 2);
  endtask

  task automatic t_reserved();
    logic [4:0] old;
    @(negedge clk);
    while (!cfg_ready) @(negedge clk);
    old = cfg_value;
    cfg_valid = 1; cfg_word = 5'b10101;
    @(negedge clk);
    cfg_valid = 0;
    check("R5 err raised", int'(cfg_err), 1);
    check("R5 no zz", int'(mem_zz_n), 1);
    check("R5 still standby", int'(pwr_state), 2);
    repeat (3) @(negedge clk);
    check("R5 value kept", int'(cfg_value), int'(old));
    check("R5 zz still high", int'(mem_zz_n), 1);
  endtask

  task automatic t_sleep(input int hold, input bit deep);
    int zl, rec, exp_len, wait_g;
    bit seen_gnt;
    @(negedge clk);
    sleep_req = 1;
    @(negedge clk);
    if (deep) begin
      check("R7 deep code", int'(pwr_state), 4);
      check("R7 contents dropped", int'(contents_valid), 0);
      acc_req = 1;
    end else check("R6 retain code", int'(pwr_state), 3);
    check("R6 zz low cs high", int'({mem_zz_n, mem_cs_n}), 2'b01);
    zl = 1;
    if (hold <= 1) sleep_req = 0;
    while (!mem_zz_n && zl < 1000) begin
      @(negedge clk);
      if (!mem_zz_n) begin zl++; if (zl >= hold) sleep_req = 0; end
    end
    exp_len = (hold > M) ? hold : M;
    check("R6 sleep length", zl, exp_len);
    if (deep) begin
      rec = 0; seen_gnt = 0;
      while (pwr_state == 3'd4 && rec < 1000) begin
        if (acc_gnt || !mem_zz_n) seen_gnt = 1;
        rec++;
        @(negedge clk);
      end
      check("R7 recovery length", rec, R);
      check("R7 no grant in recovery", int'(seen_gnt), 0);
      wait_g = 0;
      while (!acc_gnt && wait_g < 3) begin @(negedge clk); wait_g++; end
      check("R10 grant after recovery", int'(acc_gnt), 1);
      check("R10 contents back on grant", int'(contents_valid), 1);
      acc_req = 0;
      @(negedge clk);
      check("R10 grant released", int'(pwr_state), 2);
    end else check("R6 woke to standby", int'(pwr_state), 2);
  endtask

  task automatic t_grant();
    @(negedge clk);
    acc_req = 1;
    @(negedge clk);
    check("R10 grant", int'(acc_gnt), 1);
    check("R11 active code", int'(pwr_state), 1);
    check("R2 not ready in grant", int'(cfg_ready), 0);
    cfg_valid = 1; cfg_word = 5'b00000;
    repeat (3) @(negedge clk);
    check("R2 held word not taken", int'({mem_zz_n, cfg_ready}), 2'b10);
    cfg_valid = 0; sleep_req = 1;
    @(negedge clk);
    check("R10 sleep ignored in grant", int'({pwr_state, mem_zz_n}), {3'd1, 1'b1});
    sleep_req = 0; acc_req = 0;
    @(negedge clk);
    check("R10 grant drop", int'({acc_gnt, pwr_state}), {1'b0, 3'd2});
  endtask

  initial begin
    t_reset();
    t_program(5'b00011, 'h00000, 'h1FFFF, 0);
    t_program(5'b00111, 'h60000, 'h7FFFF, 0);
    t_program(5'b00110, 'h40000, 'h7FFFF, 0);
    t_program(5'b00010, 'h00000, 'h3FFFF, 0);
    t_reserved();
    check("R5 half still stored", int'(cfg_value), 5'b00010);
    t_program(5'b00100, 'h00000, 'h7FFFF, 1);
    t_sleep(1, 0);
    t_sleep(M + 10, 0);
    t_program(5'b01011, 'h00000, 'h1FFFF, 0);
    t_sleep(1, 0);
    check("R9 size kept after wake", int'(size_limited), 1);
    check("R9 config kept after wake", int'(cfg_value), 5'b01011);
    t_grant();
    t_program(5'b10000, 'h00000, 'h7FFFF, 0);
    t_sleep(1, 1);
    t_program(5'b00000, 'h00000, 'h7FFFF, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule